// File: doc/BRIEF.md
# Privilege stack trap controller

This block keeps the privilege level and interrupt-enable state of a processor hart as a three-entry stack inside a machine status word. When a trap is taken, the stack moves down one place, the hart enters machine level with interrupts off, and the trap cause and faulting PC are captured. A trap-target PC is also produced, offset from a fixed vector base by the privilege level that was active when the trap arrived. A trap return moves the stack up one place and refills the bottom entry with user level and interrupts on.

Software reaches the status word, cause and exception-PC registers through a small register port with registered read-back. Writes to the status word are filtered field by field. A privilege field takes the written code only when that code is legal, and a summary dirty bit is computed from the two extension-state fields. The control pipeline uses the current privilege and the global interrupt enable.

Top module: `psc_trap_ctrl`

## Requirements
- R1: On synchronous reset, the status word reads 0x96 (current level machine=3, level-1 and level-2 supervisor=1, every enable 0, MPRV/FS/XS 0). trap_pc reads VEC_BASE+0x100 (0x200 with defaults), and cause and exception PC read 0.
- R2: On trap_valid, the stack moves down: level-2 takes level-1, enable-2 takes enable-1, level-1 takes the current level and enable-1 takes the current enable. Status layout: bit0 enable, [2:1] level, bit3 enable-1, [5:4] level-1, bit6 enable-2, [8:7] level-2.
- R3: On trap_valid, the current level becomes machine (3), and both the current enable and MPRV (bit9) are cleared.
- R4: On ret_valid without trap_valid, the stack moves up: the current level and enable take level-1 and enable-1, and those take level-2 and enable-2. Level-2 then becomes user (0) and enable-2 becomes 1.
- R5: On a trap, trap_pc becomes VEC_BASE + 0x40 × (level current before the trap). At all other times it holds its value.
- R6: On a trap, the cause register takes trap_cause and the exception-PC register takes trap_epc.
- R7: A status write updates each of the three level fields only if the written code is 0, 1 or 3. The code 2 leaves that field unchanged.
- R8: A status write sets the three enables, MPRV, FS ([13:12]) and XS ([15:14]) directly. All other bits, bit 31 included, are ignored and read 0 apart from the dirty bit.
- R9: Bit XLEN-1 of the status word is 1 exactly when FS is 3 or XS is 3.
- R10: When several events arrive in one cycle, a trap wins over a return, and a return wins over a register write.
- R11: csr_rdata shows, one cycle later, the register chosen by csr_addr (0 status, 1 cause, 2 exception PC, 3 zero). A write with csr_addr 1 or 2 loads cause or exception PC when no trap occurs in that cycle.
- R12: cur_priv equals status bits [2:1] and glob_ie equals bit 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Take a trap this cycle |
| trap_cause | input | XLEN | Cause code of the trap |
| trap_epc | input | XLEN | PC of the trapping instruction |
| ret_valid | input | 1 | Return from trap this cycle |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 status, 1 cause, 2 exception PC |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Registered read-back of the selected register |
| cur_priv | output | 2 | Current privilege level |
| glob_ie | output | 1 | Current global interrupt enable |
| trap_pc | output | XLEN | Target PC of the most recent trap |
| status_word | output | XLEN | Assembled status word |

## Verification
A single event sequence runs traps from user, supervisor and machine level. This shows that the vector offset follows the pre-trap level and not the post-trap one. Back-to-back traps and back-to-back returns are then applied, which shows whether each stack entry moves to the correct neighbour and whether the bottom refill values are correct. Status writes use legal and illegal level codes, reserved bits and a set bit 31, and each of FS and XS at 3 and at 1; these separate field filtering from the dirty-bit logic. Simultaneous trap-and-return and trap-and-write cycles show the priority order, and a mid-run reset shows that every register returns to its initial value.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  typedef struct packed {
    logic [1:0] xs;
    logic [1:0] fs;
    logic       mprv;
    lvl_e       lvl2;
    logic       en2;
    lvl_e       lvl1;
    logic       en1;
    lvl_e       lvl0;
    logic       en0;
  } stk_t;

  localparam int P_EN0  = 0;
  localparam int P_LVL0 = 1;
  localparam int P_EN1  = 3;
  localparam int P_LVL1 = 4;
  localparam int P_EN2  = 6;
  localparam int P_LVL2 = 7;
  localparam int P_MPRV = 9;
  localparam int P_FS   = 12;
  localparam int P_XS   = 14;

  localparam int VEC_STEP_SH  = 6;      // 0x40 per level
  localparam int RESET_OFFSET = 'h100;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_CAUSE  = 2'd1;
  localparam logic [1:0] SEL_EPC    = 2'd2;

  function automatic logic lvl_legal(input logic [1:0] code);
    return code != 2'd2;
  endfunction

endpackage

// File: rtl/psc_wr_filter.sv
module psc_wr_filter
  import psc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  stk_t            cur,
  input  logic [XLEN-1:0] wdata,
  output stk_t            nxt
);
  logic [1:0] w_l0, w_l1, w_l2;

  always_comb begin
    w_l0 = wdata[P_LVL0 +: 2];
    w_l1 = wdata[P_LVL1 +: 2];
    w_l2 = wdata[P_LVL2 +: 2];
    nxt      = cur;
    nxt.en0  = wdata[P_EN0];
    nxt.en1  = wdata[P_EN1];
    nxt.en2  = wdata[P_EN2];
    nxt.mprv = wdata[P_MPRV];
    nxt.fs   = wdata[P_FS +: 2];
    nxt.xs   = wdata[P_XS +: 2];
    if (lvl_legal(w_l0)) nxt.lvl0 = lvl_e'(w_l0);
    if (lvl_legal(w_l1)) nxt.lvl1 = lvl_e'(w_l1);
    if (lvl_legal(w_l2)) nxt.lvl2 = lvl_e'(w_l2);
  end
endmodule

// File: rtl/psc_stack.sv
module psc_stack
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic wr_en,
  input  stk_t wr_val,
  output stk_t st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      st.lvl0 <= LVL_MACH;
      st.lvl1 <= LVL_SUPER;
      st.lvl2 <= LVL_SUPER;
    end else if (push) begin
      st.lvl2 <= st.lvl1;
      st.en2  <= st.en1;
      st.lvl1 <= st.lvl0;
      st.en1  <= st.en0;
      st.lvl0 <= LVL_MACH;
      st.en0  <= 1'b0;
      st.mprv <= 1'b0;
    end else if (pop) begin
      st.lvl0 <= st.lvl1;
      st.en0  <= st.en1;
      st.lvl1 <= st.lvl2;
      st.en1  <= st.en2;
      st.lvl2 <= LVL_USER;
      st.en2  <= 1'b1;
    end else if (wr_en) begin
      st <= wr_val;
    end
  end
endmodule

// File: rtl/psc_trap_regs.sv
module psc_trap_regs
  import psc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] epc_in,
  input  logic [1:0]      lvl_now,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] tpc_q
);
  localparam logic [XLEN-1:0] BASE_V  = XLEN'(VEC_BASE);
  localparam logic [XLEN-1:0] RESET_V = XLEN'(VEC_BASE + RESET_OFFSET);

  logic [XLEN-1:0] lvl_ext;
  assign lvl_ext = {{(XLEN-2){1'b0}}, lvl_now};

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
      tpc_q   <= RESET_V;
    end else if (trap) begin
      cause_q <= cause_in;
      epc_q   <= epc_in;
      tpc_q   <= BASE_V + (lvl_ext << VEC_STEP_SH);
    end else if (we) begin
      if (sel == SEL_CAUSE) cause_q <= wdata;
      if (sel == SEL_EPC)   epc_q   <= wdata;
    end
  end
endmodule

// File: rtl/psc_trap_ctrl.sv
module psc_trap_ctrl
  import psc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic            ret_valid,
  input  logic            csr_we,
  input  logic [1:0]      csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [1:0]      cur_priv,
  output logic            glob_ie,
  output logic [XLEN-1:0] trap_pc,
  output logic [XLEN-1:0] status_word
);
  stk_t            st, st_wr;
  logic            st_we;
  logic [XLEN-1:0] cause_q, epc_q;

  assign st_we = csr_we && (csr_addr == SEL_STATUS);

  psc_wr_filter #(.XLEN(XLEN)) u_filt (
    .cur(st), .wdata(csr_wdata), .nxt(st_wr)
  );

  psc_stack u_stk (
    .clk(clk), .rst(rst), .push(trap_valid), .pop(ret_valid),
    .wr_en(st_we), .wr_val(st_wr), .st(st)
  );

  psc_trap_regs #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_regs (
    .clk(clk), .rst(rst), .trap(trap_valid), .cause_in(trap_cause),
    .epc_in(trap_epc), .lvl_now(st.lvl0), .we(csr_we), .sel(csr_addr),
    .wdata(csr_wdata), .cause_q(cause_q), .epc_q(epc_q), .tpc_q(trap_pc)
  );

  always_comb begin
    status_word               = '0;
    status_word[P_EN0]        = st.en0;
    status_word[P_LVL0 +: 2]  = st.lvl0;
    status_word[P_EN1]        = st.en1;
    status_word[P_LVL1 +: 2]  = st.lvl1;
    status_word[P_EN2]        = st.en2;
    status_word[P_LVL2 +: 2]  = st.lvl2;
    status_word[P_MPRV]       = st.mprv;
    status_word[P_FS +: 2]    = st.fs;
    status_word[P_XS +: 2]    = st.xs;
    status_word[XLEN-1]       = (&st.fs) | (&st.xs);
  end

  assign cur_priv = st.lvl0;
  assign glob_ie  = st.en0;

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      case (csr_addr)
        SEL_STATUS: csr_rdata <= status_word;
        SEL_CAUSE:  csr_rdata <= cause_q;
        SEL_EPC:    csr_rdata <= epc_q;
        default:    csr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/psc_trap_ctrl_chk.sv
module psc_trap_ctrl_chk #(
  parameter int          XLEN     = 32,
  parameter int unsigned VEC_BASE = 'h100
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_valid,
  input logic            ret_valid,
  input logic [1:0]      cur_priv,
  input logic            glob_ie,
  input logic [XLEN-1:0] trap_pc,
  input logic [XLEN-1:0] status_word
);
  // R2
  lvl_push_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> (status_word[5:4] == $past(cur_priv)) && (status_word[3] == $past(glob_ie)));

  // R3
  mach_entry_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> (cur_priv == 2'd3) && !glob_ie && !status_word[9]);

  // R4
  ret_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !trap_valid) |=> (status_word[8:7] == 2'd0) && status_word[6]
                                   && (cur_priv == $past(status_word[5:4])));

  // R5
  vec_target_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> trap_pc == XLEN'(VEC_BASE) + XLEN'({$past(cur_priv), 6'd0}));

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> $stable(trap_pc));

  // R7
  no_rsvd_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (status_word[2:1] != 2'd2) && (status_word[5:4] != 2'd2) && (status_word[8:7] != 2'd2));

  // R10
  trap_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && ret_valid) |=> (status_word[5:4] == $past(cur_priv)));
endmodule

bind psc_trap_ctrl psc_trap_ctrl_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .trap_valid(trap_valid), .ret_valid(ret_valid),
  .cur_priv(cur_priv), .glob_ie(glob_ie), .trap_pc(trap_pc),
  .status_word(status_word)
);

// File: tb/tb_psc_trap_ctrl.sv
module tb_psc_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trap_valid = 1'b0, ret_valid = 1'b0, csr_we = 1'b0;
  logic [XLEN-1:0] trap_cause = '0, trap_epc = '0, csr_wdata = '0;
  logic [1:0]      csr_addr = 2'd0;
  logic [XLEN-1:0] csr_rdata, trap_pc, status_word;
  logic [1:0]      cur_priv;
  logic            glob_ie;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psc_trap_ctrl #(.XLEN(XLEN), .VEC_BASE('h100)) dut (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .ret_valid(ret_valid), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cur_priv(cur_priv), .glob_ie(glob_ie), .trap_pc(trap_pc),
    .status_word(status_word)
  );

  // op: 0 trap, 1 return, 2 status write, 3 trap+return, 4 trap+status write
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] wd;
    logic [31:0] st;
    logic [31:0] pc;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{3'd2, 32'h0000_02F1, 32'h0000_02F1, 32'h0000_0200},
    '{3'd0, 32'h0,         32'h0000_018E, 32'h0000_0100},
    '{3'd0, 32'h0,         32'h0000_0076, 32'h0000_01C0},
    '{3'd1, 32'h0,         32'h0000_004E, 32'h0000_01C0},
    '{3'd1, 32'h0,         32'h0000_0049, 32'h0000_01C0},
    '{3'd2, 32'h0000_3114, 32'h8000_3010, 32'h0000_01C0},
    '{3'd0, 32'h0,         32'h8000_3086, 32'h0000_0100},
    '{3'd3, 32'h0,         32'h8000_3036, 32'h0000_01C0},
    '{3'd2, 32'h0000_C002, 32'h8000_C002, 32'h0000_01C0},
    '{3'd2, 32'h0000_5002, 32'h0000_5002, 32'h0000_01C0},
    '{3'd0, 32'h0,         32'h0000_5016, 32'h0000_0140},
    '{3'd2, 32'hFFFF_5C16, 32'h0000_5016, 32'h0000_0140},
    '{3'd4, 32'h0000_0001, 32'h0000_50B6, 32'h0000_01C0}
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0:    return "R2 R3 R5";
      3'd1:    return "R4 R5";
      3'd2:    return "R7 R8 R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values, visible while reset holds
    check("R1 status", status_word, 32'h96);
    check("R1 pc", trap_pc, 32'h200);
    check("R1 priv", {30'd0, cur_priv}, 32'd3);
    rst = 1'b0;
    csr_addr = 2'd0;
    @(negedge clk);
    check("R11 status readback", csr_rdata, 32'h96);
    csr_addr = 2'd1;
    @(negedge clk);
    check("R1 cause", csr_rdata, 32'h0);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      v = VECS[i];
      trap_valid = (v.op == 3'd0) || (v.op == 3'd3) || (v.op == 3'd4);
      ret_valid  = (v.op == 3'd1) || (v.op == 3'd3);
      csr_we     = (v.op == 3'd2) || (v.op == 3'd4);
      csr_addr   = 2'd0;
      csr_wdata  = v.wd;
      trap_cause = 32'h20 + i;
      trap_epc   = 32'h4000 + 4 * i;
      @(negedge clk);
      trap_valid = 1'b0; ret_valid = 1'b0; csr_we = 1'b0;
      check(op_tag(v.op), status_word, v.st);
      check({op_tag(v.op), " R5 pc"}, trap_pc, v.pc);
      check("R12 priv", {30'd0, cur_priv}, {30'd0, v.st[2:1]});
      check("R12 ie", {31'd0, glob_ie}, {31'd0, v.st[0]});
    end

    // R6 / R11: cause and epc of the last trap (row 12)
    csr_addr = 2'd1;
    @(negedge clk);
    @(negedge clk);
    check("R6 cause", csr_rdata, 32'h2C);
    csr_addr = 2'd2;
    @(negedge clk);
    check("R6 epc", csr_rdata, 32'h4030);
    csr_addr = 2'd3;
    @(negedge clk);
    check("R11 unused select", csr_rdata, 32'h0);

    // R11: cause write through the register port, status untouched
    csr_we = 1'b1; csr_addr = 2'd1; csr_wdata = 32'hABCD;
    @(negedge clk);
    csr_we = 1'b0;
    @(negedge clk);
    check("R11 cause write", csr_rdata, 32'hABCD);
    check("R11 status kept", status_word, 32'h50B6);

    // R10: trap beats a same-cycle epc write
    trap_valid = 1'b1; trap_epc = 32'h7770; trap_cause = 32'h5;
    csr_we = 1'b1; csr_addr = 2'd2; csr_wdata = 32'h1234;
    @(negedge clk);
    trap_valid = 1'b0; csr_we = 1'b0;
    @(negedge clk);
    check("R10 epc trap wins", csr_rdata, 32'h7770);

    // R1: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 status again", status_word, 32'h96);
    check("R1 pc again", trap_pc, 32'h200);
    rst = 1'b0;
    csr_addr = 2'd2;
    @(negedge clk);
    check("R1 epc cleared", csr_rdata, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule